// File: doc/BRIEF.md
# Free-Running Prescaled Watchdog Timer

This block is a watchdog peripheral for a small microcontroller. A 7-bit down-counter steps once per prescaler period. The period is 49,152 clock cycles by default. When the watchdog is enabled and counter bit 6 drops from one to zero, the block drives an active-low reset request for a fixed number of cycles. Software must reload the counter in time to stop this. The reload goes through one 8-bit control register. Bits 6:0 hold the count and bit 7 is the enable.

The counter keeps running while the watchdog is disabled. In that state a bit-6 transition has no effect. Once software sets the enable bit, it can only be cleared by a reset pulse or a system reset.

Two static configuration inputs change the behaviour:
- One makes the watchdog active from reset without any software write.
- The other lets a HALT indication from the processor start a reset.

When a reset pulse ends, the block returns to its reset state.

Top module: `wdg_top`

## Requirements
- R1: After system reset, `wdgRstN` is 1 and `rdData` reads `{hwWdgMode, 7'h7F}` (bit 7 is the enable bit, bits 6:0 the counter).
- R2: A write (`wrEn`=1) loads bits 6:0 of `wrData` into the counter and clears the prescaler. The counter then decrements by one exactly every `PRESC_DIV` cycles and is unchanged in between.
- R3: With the enable bit set, the prescaler step that takes the counter from 0x40 to 0x3F starts a reset pulse. The pulse starts on the clock edge of that step and `wdgRstN` stays 0 for exactly `RST_LEN` cycles.
- R4: With the enable bit clear, the counter passes 0x40 to 0x3F without a reset and keeps counting down, wrapping from 0x00 to 0x7F.
- R5: Once set, the enable bit stays set. A write with `wrData[7]`=0 leaves it at 1 while the counter bits load normally.
- R6: A write with `wrData[6]`=0 starts a reset pulse on its clock edge if the enable bit is already set or the write sets it.
- R7: With `haltRstEn`=1, a `haltReq` of 1 starts a reset pulse on the next edge. With `haltRstEn`=0, `haltReq` has no effect.
- R8: With `hwWdgMode`=1, the watchdog is enabled from reset without any write, so with no refresh the pulse starts `64*PRESC_DIV` cycles after reset release.
- R9: Writes during a reset pulse are ignored. When the pulse ends, `rdData` reads `{hwWdgMode, 7'h7F}` and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Write data: bit 7 enable, bits 6:0 counter |
| rdData | output | 8 | Live readback: bit 7 enable, bits 6:0 counter |
| hwWdgMode | input | 1 | Static config: watchdog enabled from reset |
| haltRstEn | input | 1 | Static config: HALT indication causes reset |
| haltReq | input | 1 | HALT indication from the processor |
| wdgRstN | output | 1 | Active-low reset request pulse |

## Verification
The bench times the decrement interval after a refresh. A design that did not clear the prescaler on a write would decrement early.

It also measures the reset point and pulse width to the cycle. A design that fired at zero, or that ignored the enable bit, would miss the 0x40 to 0x3F trigger or fire while disabled.

Several cases target the enable bit:
- A write with bit 7 clear checks that enable is sticky.
- A write with bit 6 clear checks that the design resets at once rather than counting on from a low value.
- A write during the pulse checks that it does not leak into the reloaded state.

Two further cases check that HALT only resets when its option is selected, and that hardware mode fires after 64 periods with no write at all.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 7;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_PULSE = 1'b1
  } wdgState_t;

  typedef struct packed {
    logic loadCnt;
    logic reinit;
  } ctlStrobes_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int PRESC_DIV = 49152
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwWdgMode,
  input  ctlStrobes_t      strb,
  input  logic [7:0]       wrData,
  output logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             enable
);
  localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  logic [PRESC_W-1:0] presc;

  assign tick = (presc == PRESC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc  <= '0;
      cnt    <= CNT_INIT;
      enable <= hwWdgMode;
    end else if (strb.reinit) begin
      presc  <= '0;
      cnt    <= CNT_INIT;
      enable <= hwWdgMode;
    end else if (strb.loadCnt) begin
      presc  <= '0;
      cnt    <= wrData[CNT_W-1:0];
      enable <= enable | wrData[7];
    end else if (tick) begin
      presc  <= '0;
      cnt    <= cnt - 1'b1;
    end else begin
      presc  <= presc + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int RST_LEN = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             haltReq,
  input  logic             haltRstEn,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             enable,
  output ctlStrobes_t      strb,
  output logic             wdgRstN
);
  localparam int PLS_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(RST_LEN - 1);
  localparam logic [CNT_W-1:0] ROLL_AT = CNT_W'(7'h40);

  wdgState_t       state;
  logic [PLS_W-1:0] pulseCnt;
  logic            running;
  logic            fireRoll;
  logic            fireWrite;
  logic            fireHalt;
  logic            fire;

  assign running   = (state == ST_RUN);
  assign fireRoll  = tick && (cnt == ROLL_AT) && enable && !wrEn;
  assign fireWrite = wrEn && !wrData[6] && (enable || wrData[7]);
  assign fireHalt  = haltReq && haltRstEn;
  assign fire      = running && (fireRoll || fireWrite || fireHalt);

  always_comb begin
    strb.loadCnt = running && wrEn;
    strb.reinit  = !running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      pulseCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (fire) begin
            state    <= ST_PULSE;
            pulseCnt <= PLS_LAST;
          end
        end
        ST_PULSE: begin
          if (pulseCnt == '0) state <= ST_RUN;
          else                pulseCnt <= pulseCnt - 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign wdgRstN = running;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int PRESC_DIV = 49152,
  parameter int RST_LEN   = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       hwWdgMode,
  input  logic       haltRstEn,
  input  logic       haltReq,
  output logic       wdgRstN
);
  ctlStrobes_t      strb;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             enable;

  wdg_datapath #(.PRESC_DIV(PRESC_DIV)) uDp (
    .clk(clk), .rstN(rstN), .hwWdgMode(hwWdgMode), .strb(strb),
    .wrData(wrData), .tick(tick), .cnt(cnt), .enable(enable)
  );

  wdg_control #(.RST_LEN(RST_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .haltReq(haltReq), .haltRstEn(haltRstEn), .tick(tick), .cnt(cnt),
    .enable(enable), .strb(strb), .wdgRstN(wdgRstN)
  );

  assign rdData = {enable, cnt};
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] rdData,
  input logic       hwWdgMode,
  input logic       haltRstEn,
  input logic       haltReq,
  input logic       wdgRstN,
  input logic       tick
);
  AST_ROLL_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (wdgRstN && tick && !wrEn && rdData[7] && rdData[6:0] == 7'h40) |=> !wdgRstN); // R3

  AST_DISABLED_NO_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (wdgRstN && tick && !wrEn && !rdData[7] && rdData[6:0] == 7'h40
     && !(haltReq && haltRstEn)) |=> wdgRstN); // R4

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    (wdgRstN && !wrEn && !tick) |=> $stable(rdData[6:0])); // R2

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wdgRstN && rdData[7]) |=> rdData[7]); // R5

  AST_PULSE_END_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdgRstN) |-> (rdData == {hwWdgMode, 7'h7F})); // R9

  AST_HALT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (wdgRstN && haltReq && haltRstEn) |=> !wdgRstN); // R7
endmodule

bind wdg_top wdg_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdData(rdData),
  .hwWdgMode(hwWdgMode), .haltRstEn(haltRstEn), .haltReq(haltReq),
  .wdgRstN(wdgRstN), .tick(tick)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  localparam int PD = 8;
  localparam int RL = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       hwWdgMode = 1'b0;
  logic       haltRstEn = 1'b0;
  logic       haltReq = 1'b0;
  logic       wdgRstN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdg_top #(.PRESC_DIV(PD), .RST_LEN(RL)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .hwWdgMode(hwWdgMode), .haltRstEn(haltRstEn), .haltReq(haltReq),
    .wdgRstN(wdgRstN)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic hw);
    @(negedge clk);
    rstN = 1'b0; hwWdgMode = hw; wrEn = 1'b0; haltReq = 1'b0;
    waitN(3);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testResetState();
    doReset(1'b0);
    check("R1 rst", {wdgRstN, rdData}, {1'b1, 8'h7F});
  endtask

  task automatic testDecrement();
    doReset(1'b0);
    waitN(5);
    busWrite(8'h25);
    waitN(PD - 1);
    check("R2 hold", {wdgRstN, rdData}, {1'b1, 8'h25});
    waitN(1);
    check("R2 dec1", {wdgRstN, rdData}, {1'b1, 8'h24});
    waitN(PD);
    check("R2 dec2", {wdgRstN, rdData}, {1'b1, 8'h23});
  endtask

  task automatic testDisabledWrap();
    doReset(1'b0);
    busWrite(8'h41);
    waitN(2 * PD);
    check("R4 pass40", {wdgRstN, rdData}, {1'b1, 8'h3F});
    busWrite(8'h01);
    waitN(PD);
    check("R4 zero", {wdgRstN, rdData}, {1'b1, 8'h00});
    waitN(PD);
    check("R4 wrap", {wdgRstN, rdData}, {1'b1, 8'h7F});
  endtask

  task automatic testRollover();
    doReset(1'b0);
    busWrite(8'hC1);
    waitN(2 * PD - 1);
    check("R3 before", {8'h0, wdgRstN}, 9'h1);
    waitN(1);
    check("R3 fire", {8'h0, wdgRstN}, 9'h0);
    waitN(RL - 1);
    check("R3 width", {8'h0, wdgRstN}, 9'h0);
    waitN(1);
    check("R3 end", {wdgRstN, rdData}, {1'b1, 8'h7F});
  endtask

  task automatic testSticky();
    doReset(1'b0);
    busWrite(8'hC8);
    busWrite(8'h50);
    check("R5 sticky", {wdgRstN, rdData}, {1'b1, 8'hD0});
  endtask

  task automatic testLowWrite();
    doReset(1'b0);
    busWrite(8'hA0);
    check("R6 setlow", {8'h0, wdgRstN}, 9'h0);
    doReset(1'b0);
    busWrite(8'hC4);
    busWrite(8'h30);
    check("R6 enlow", {8'h0, wdgRstN}, 9'h0);
    doReset(1'b0);
    busWrite(8'h20);
    check("R6 dislow", {wdgRstN, rdData}, {1'b1, 8'h20});
  endtask

  task automatic testHalt();
    doReset(1'b0);
    haltRstEn = 1'b0;
    @(negedge clk); haltReq = 1'b1;
    waitN(3);
    check("R7 ignored", {8'h0, wdgRstN}, 9'h1);
    haltReq = 1'b0;
    haltRstEn = 1'b1;
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); haltReq = 1'b0;
    check("R7 halt", {8'h0, wdgRstN}, 9'h0);
    haltRstEn = 1'b0;
    waitN(RL);
    check("R7 end", {8'h0, wdgRstN}, 9'h1);
  endtask

  task automatic testHwMode();
    int n;
    doReset(1'b1);
    check("R8 en", {wdgRstN, rdData}, {1'b1, 8'hFF});
    n = 0;
    while (wdgRstN && n < 64 * PD + 50) begin
      @(negedge clk);
      n++;
    end
    check("R8 time", 9'(n), 9'(64 * PD));
    waitN(RL);
    check("R8 after", {wdgRstN, rdData}, {1'b1, 8'hFF});
  endtask

  task automatic testWriteDuringPulse();
    doReset(1'b0);
    busWrite(8'hA0);
    busWrite(8'hC5);
    waitN(RL - 2);
    check("R9 end", {wdgRstN, rdData}, {1'b1, 8'h7F});
    waitN(PD - 1);
    check("R9 presc", {wdgRstN, rdData}, {1'b1, 8'h7F});
    waitN(1);
    check("R9 dec", {wdgRstN, rdData}, {1'b1, 8'h7E});
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testDecrement();
    testDisabledWrap();
    testRollover();
    testSticky();
    testLowWrite();
    testHalt();
    testHwMode();
    testWriteDuringPulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule